// File: doc/BRIEF.md
# Closed-Page DRAM Bank Scheduler

This block is the state machine for one DRAM bank. It serves one request at a time. Each request carries a read/write flag, a row, a column and write data. An accepted request always runs the same three commands in the same order: the row is opened, the column is accessed, and the row is closed again. A row is therefore never left open, and two requests cannot share an open row. Every gap between commands is timed by a down-counter. The counter is reloaded from a module parameter each time the machine enters a new state.

Refresh and self-refresh are states of the same machine. A refresh request is latched when it arrives. It runs the next time the bank is idle, so it never cuts into an access that has already started. Self-refresh is a low-power state with its own entry and exit: it can be entered only from idle, and leaving it costs a fixed exit delay. A small behavioural array holds the written data, so that reads return exactly what was last written to that row and column.

The block emits one-cycle strobes for its three commands. A bank-level arbiter or a trace-driven harness can use these strobes to observe or account for the commands.

Top module: `dram_bank_sched`

## Requirements
- R1: An accepted request produces, in this order, exactly one `cmd_act` strobe, one `cmd_col` strobe and one `cmd_pre` strobe. Each strobe lasts one cycle, and no `cmd_act` occurs while a row is open. `cmd_act` is high in the cycle right after the accepting clock edge.
- R2: `cmd_col` rises exactly T_RCD cycles after `cmd_act`.
- R3: `cmd_pre` follows one cycle after the response. `req_ready` returns exactly T_RP cycles after `cmd_pre`, so the next activate is separated from the precharge by more than T_RP cycles.
- R4: `rsp_valid` is a one-cycle pulse, T_CAS-1 cycles after `cmd_col`. On that pulse, `rsp_write` is 1 for a write and 0 for a read.
- R5: A read response carries the data last written to the same {row, column}, or zero if that address has never been written since reset. A write response carries zero data.
- R6: `req_ready` is high only when the bank is idle, no refresh is pending, and `sr_enter` is low. It is low in every other state.
- R7: A `ref_req` pulse seen while the bank is idle drops `req_ready` in the next cycle. `req_ready` then stays low for T_RFC+1 cycles, and no `cmd_act` is issued during that time.
- R8: A `ref_req` pulse that arrives during an access does not disturb that access: its command timing and response are unchanged. The refresh then runs before any further request is accepted, so `req_ready` comes back T_RFC+1 cycles later than it would have without the refresh.
- R9: A pending refresh wins over a waiting request and over `sr_enter`. The request is accepted only once the refresh has finished, and `cmd_act` follows T_RFC+3 cycles after the `ref_req` pulse.
- R10: `sr_enter` while idle sets `lp_active` in the next cycle. `lp_active` then stays high, with `req_ready` low and no `cmd_act`, until `sr_exit` is given.
- R11: After `sr_exit`, `lp_active` drops in the next cycle. `req_ready` returns T_XSR+1 cycles after the exit pulse.
- R12: `sr_enter` outside idle has no effect: `lp_active` stays low and the access timing is unchanged. `sr_exit` outside self-refresh also has no effect.
- R13: After reset, `req_ready` is 1, and `rsp_valid`, `lp_active` and all command strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_write | output | 1 | Response is a write acknowledge |
| rsp_rdata | output | DATA_W | Read data, zero for writes |
| ref_req | input | 1 | Refresh request pulse |
| sr_enter | input | 1 | Self-refresh entry request |
| sr_exit | input | 1 | Self-refresh exit request |
| lp_active | output | 1 | Bank is in self-refresh |
| cmd_act | output | 1 | Activate strobe |
| cmd_col | output | 1 | Column read/write strobe |
| cmd_pre | output | 1 | Precharge strobe |

## Verification
Some properties are checked on every cycle by the assertions. These are the command order against an open-row flag, the exact activate-to-column gap, the precharge-to-activate spacing, the column-to-response gap, readiness never overlapping an open row or low power, and the rule that low power starts only after an entry request. Other behaviour can only be shown by the bench scenarios. This covers refresh deferral and refresh priority, the exact lengths of the refresh window and the self-refresh exit window, the requests ignored during refresh and self-refresh, and bit-exact read data after random sequences of writes that hit the same addresses.

// File: rtl/dram_bank_pkg.sv
package dram_bank_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_COL, ST_PRE, ST_REF, ST_SREF, ST_SRX
  } bank_st_e;

  // Number of cycles the machine dwells in a state before it may leave.
  function automatic int unsigned dwell(bank_st_e s, int unsigned rcd, int unsigned cas,
                                        int unsigned rp, int unsigned rfc, int unsigned xsr);
    case (s)
      ST_ACT:  return rcd;
      ST_COL:  return cas;
      ST_PRE:  return rp;
      ST_REF:  return rfc;
      ST_SRX:  return xsr;
      default: return 1;
    endcase
  endfunction

  function automatic int unsigned max5(int unsigned a, int unsigned b, int unsigned c,
                                       int unsigned d, int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/bank_timer.sv
module bank_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/bank_store.sv
module bank_store #(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/dram_bank_sched.sv
module dram_bank_sched
  import dram_bank_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 3,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 3,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 3,
  parameter int T_RFC  = 6,
  parameter int T_XSR  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ref_req,
  input  logic              sr_enter,
  input  logic              sr_exit,
  output logic              lp_active,
  output logic              cmd_act,
  output logic              cmd_col,
  output logic              cmd_pre
);
  localparam int MAXD = int'(max5(T_RCD, T_CAS, T_RP, T_RFC, T_XSR));
  localparam int CW   = $clog2(MAXD + 1);
  localparam int AW   = ROW_W + COL_W;
  localparam int GW   = CW + 2;

  initial assert (T_RCD >= 1 && T_CAS >= 1 && T_RP >= 1 && T_RFC >= 1 && T_XSR >= 1);

  bank_st_e state, state_nxt;
  logic     entry;
  logic     ref_pend;
  logic     tmr_done;
  logic     accept;
  logic     lat_wr;
  logic [ROW_W-1:0]  lat_row;
  logic [COL_W-1:0]  lat_col;
  logic [DATA_W-1:0] lat_wdata;
  logic [DATA_W-1:0] store_rd;
  logic [CW-1:0]     tmr_val;

  assign req_ready = (state == ST_IDLE) && !ref_pend && !sr_enter;
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE: begin
        if (ref_pend)       state_nxt = ST_REF;
        else if (sr_enter)  state_nxt = ST_SREF;
        else if (req_valid) state_nxt = ST_ACT;
      end
      ST_ACT:  if (tmr_done) state_nxt = ST_COL;
      ST_COL:  if (tmr_done) state_nxt = ST_PRE;
      ST_PRE:  if (tmr_done) state_nxt = ST_IDLE;
      ST_REF:  if (tmr_done) state_nxt = ST_IDLE;
      ST_SREF: if (sr_exit)  state_nxt = ST_SRX;
      ST_SRX:  if (tmr_done) state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  assign tmr_val = CW'(dwell(state_nxt, T_RCD, T_CAS, T_RP, T_RFC, T_XSR) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      entry    <= 1'b0;
      ref_pend <= 1'b0;
    end else begin
      state <= state_nxt;
      entry <= (state_nxt != state);
      if (state_nxt == ST_REF)
        ref_pend <= 1'b0;
      else if (ref_req && state != ST_SREF && state != ST_SRX)
        ref_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_wr <= 1'b0; lat_row <= '0; lat_col <= '0; lat_wdata <= '0;
    end else if (accept) begin
      lat_wr <= req_write; lat_row <= req_row; lat_col <= req_col; lat_wdata <= req_wdata;
    end
  end

  bank_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(state_nxt != state), .load_val(tmr_val), .done(tmr_done)
  );

  bank_store #(.AW(AW), .DW(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(cmd_col && lat_wr), .addr({lat_row, lat_col}),
    .wdata(lat_wdata), .rdata(store_rd)
  );

  assign cmd_act   = (state == ST_ACT) && entry;
  assign cmd_col   = (state == ST_COL) && entry;
  assign cmd_pre   = (state == ST_PRE) && entry;
  assign rsp_valid = (state == ST_COL) && tmr_done;
  assign rsp_write = rsp_valid && lat_wr;
  assign rsp_rdata = (rsp_valid && !lat_wr) ? store_rd : '0;
  assign lp_active = (state == ST_SREF);

  // ---------------- assertions: command-level observers ----------------
  logic          row_open;
  logic [GW-1:0] gap_act, gap_pre, gap_col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open <= 1'b0;
      gap_act <= '1; gap_pre <= '1; gap_col <= '1;
    end else begin
      if (cmd_act) row_open <= 1'b1;
      else if (cmd_pre) row_open <= 1'b0;
      gap_act <= cmd_act ? GW'(1) : (gap_act == '1 ? gap_act : gap_act + 1'b1);
      gap_pre <= cmd_pre ? GW'(1) : (gap_pre == '1 ? gap_pre : gap_pre + 1'b1);
      gap_col <= cmd_col ? GW'(1) : (gap_col == '1 ? gap_col : gap_col + 1'b1);
    end
  end

  // R1
  act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |-> !row_open);
  // R1
  col_pre_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_col || cmd_pre) |-> row_open);
  // R2
  rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_col |-> gap_act == GW'(T_RCD));
  // R3
  rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |-> gap_pre > GW'(T_RP));
  // R4
  cas_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((T_CAS == 1) ? cmd_col : (gap_col == GW'(T_CAS - 1))));
  // R6
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!row_open && !lp_active));
  // R10
  lp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_active) |-> $past(sr_enter));
endmodule

// File: tb/test_dram_bank_sched.sv
module test_dram_bank_sched;
  localparam int ROW_W = 4, COL_W = 3, DATA_W = 16;
  localparam int T_RCD = 3, T_CAS = 2, T_RP = 3, T_RFC = 6, T_XSR = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, ref_req = 0, sr_enter = 0, sr_exit = 0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_write, lp_active, cmd_act, cmd_col, cmd_pre;
  logic [DATA_W-1:0] rsp_rdata;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [DATA_W-1:0] model [128];

  always #5 clk = ~clk;

  dram_bank_sched #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .T_RP(T_RP), .T_RFC(T_RFC), .T_XSR(T_XSR)) i_dram_bank_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_rdata(rsp_rdata),
    .ref_req(ref_req), .sr_enter(sr_enter), .sr_exit(sr_exit), .lp_active(lp_active),
    .cmd_act(cmd_act), .cmd_col(cmd_col), .cmd_pre(cmd_pre));

  // Expected cycle indices, counted in falling edges after the accepting edge.
  function automatic int col_at();  return T_RCD + 1; endfunction
  function automatic int rsp_at();  return col_at() + T_CAS - 1; endfunction
  function automatic int pre_at();  return rsp_at() + 1; endfunction
  function automatic int rdy_at(bit with_ref);
    return pre_at() + T_RP + (with_ref ? T_RFC + 1 : 0);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  // One access; inj: 0 none, 1 refresh pulse mid-access, 2 sr_enter pulse mid-access.
  task automatic access(bit wr, int row, int col, logic [DATA_W-1:0] d, int inj);
    int act_i = -1, col_i = -1, rsp_i = -1, pre_i = -1, rdy_i = -1, acts = 0, lp_seen = 0;
    int rsp_wr = -1, rsp_dat = -1;
    int exp_dat;
    wait_ready();
    req_valid = 1; req_write = wr; req_row = ROW_W'(row); req_col = COL_W'(col); req_wdata = d;
    @(posedge clk);
    for (int i = 1; i < 60 && rdy_i < 0; i++) begin
      @(negedge clk);
      req_valid = 0;
      ref_req  = (inj == 1 && i == 2);
      sr_enter = (inj == 2 && i == 2);
      if (cmd_act) begin acts++; if (act_i < 0) act_i = i; end
      if (cmd_col && col_i < 0) col_i = i;
      if (cmd_pre && pre_i < 0) pre_i = i;
      if (rsp_valid && rsp_i < 0) begin rsp_i = i; rsp_wr = rsp_write; rsp_dat = rsp_rdata; end
      if (lp_active) lp_seen = 1;
      if (req_ready && !sr_enter) rdy_i = i;
    end
    ref_req = 0; sr_enter = 0;
    exp_dat = wr ? 0 : model[row*8 + col];
    if (wr) model[row*8 + col] = d;
    check("R1 act index", act_i, 1);
    check("R1 single act", acts, 1);
    check("R2 col index", col_i, col_at());
    check("R4 rsp index", rsp_i, rsp_at());
    check("R4 rsp_write", rsp_wr, wr);
    check("R5 rsp data", rsp_dat, exp_dat);
    check("R3 pre index", pre_i, pre_at());
    if (inj == 1) check("R8 ready after deferred refresh", rdy_i, rdy_at(1));
    else          check("R3 ready index", rdy_i, rdy_at(0));
    if (inj == 2) check("R12 sr_enter ignored while busy", lp_seen, 0);
  endtask

  initial begin
    int lo, rdy_i, act_i;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 128; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    check("R13 ready", req_ready, 1);
    check("R13 rsp", rsp_valid, 0);
    check("R13 lp", lp_active, 0);
    check("R13 cmds", {cmd_act, cmd_col, cmd_pre}, 0);

    // directed accesses; R5 unwritten address reads zero
    access(0, 5, 5, '0, 0);
    access(1, 2, 3, 16'hbeef, 0);
    access(0, 2, 3, '0, 0);
    access(1, 2, 3, 16'h1234, 1);
    access(0, 2, 3, '0, 2);

    // R7 idle refresh window
    wait_ready();
    ref_req = 1;
    @(negedge clk); ref_req = 0;
    lo = 0;
    for (int i = 1; i < 40 && !req_ready; i++) begin
      lo++;
      if (cmd_act) check("R7 no act in refresh", 1, 0);
      @(negedge clk);
    end
    check("R7 ready low cycles", lo, T_RFC + 1);

    // R9 refresh wins over a waiting request and sr_enter
    wait_ready();
    ref_req = 1;
    @(negedge clk);
    ref_req = 0;
    check("R9 ready low after pend", req_ready, 0);
    req_valid = 1; req_write = 0; req_row = 4'd1; req_col = 3'd1; sr_enter = 1;
    act_i = -1; rdy_i = -1;
    for (int i = 2; i < 40 && act_i < 0; i++) begin
      @(negedge clk);
      sr_enter = 0;
      if (req_ready && rdy_i < 0) rdy_i = i;
      if (cmd_act) begin act_i = i; req_valid = 0; end
      if (lp_active) check("R9 no self-refresh", 1, 0);
    end
    req_valid = 0;
    check("R9 ready index", rdy_i, T_RFC + 2);
    check("R9 act index", act_i, T_RFC + 3);
    @(negedge clk);
    wait_ready();

    // R12 sr_exit in idle ignored
    sr_exit = 1;
    @(negedge clk); sr_exit = 0;
    @(negedge clk);
    check("R12 sr_exit idle lp", lp_active, 0);
    check("R12 sr_exit idle ready", req_ready, 1);

    // R10 self-refresh entry and hold
    sr_enter = 1;
    @(negedge clk); sr_enter = 0;
    check("R10 lp after entry", lp_active, 1);
    req_valid = 1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!lp_active || req_ready || cmd_act) check("R10 hold self-refresh", 1, 0);
    end
    req_valid = 0;
    // R11 exit latency
    sr_exit = 1;
    @(negedge clk); sr_exit = 0;
    check("R11 lp drops", lp_active, 0);
    rdy_i = -1;
    for (int i = 1; i < 40 && rdy_i < 0; i++) begin
      if (req_ready) rdy_i = i;
      else @(negedge clk);
    end
    check("R11 ready after exit", rdy_i, T_XSR + 1);

    // random traffic over a small address window
    for (int n = 0; n < 80; n++) begin
      bit wr = 1'($urandom % 2);
      int r = int'($urandom % 3);
      int c = int'($urandom % 8);
      int inj = (n % 11 == 5) ? 1 : ((n % 13 == 7) ? 2 : 0);
      access(wr, r, c, 16'($urandom), inj);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule